// File: doc/BRIEF.md
# Emulated Printer Port Register Block

This block presents a host-side printer port as three byte registers on a simple single-cycle register bus. The host writes a byte into the data register, then drives a strobe sequence through the control register. When the strobe rises while the printer is selected and out of initialisation, the stored byte is handed on as a one-cycle valid/data pulse on the byte output.

The printer side of the cable is not sampled from pins. It is modelled inside the block. Every read of the status register moves a small ACK/BUSY handshake forward by one step and clears any pending interrupt. A level interrupt output is raised when an interrupt is pending and the control register enables interrupts.

Bus rules: a request lasts one cycle. Read data appears on `rd_data` in the cycle after the read strobe and holds until the next read. Read and write are never requested in the same cycle.

Top module: `prn_port_regs`

## Requirements
- R1: Decoding uses only the low three address bits. Offset 0 is data, offset 1 is status and offset 2 is control. Offsets 3 to 7 read as 0x00, and writes to them change nothing.
- R2: After reset the status register reads 0x80 (BUSY only), data and control read 0x00, `irq` is low and `out_valid` is low.
- R3: A control write with INIT (bit 2) at 0 sets status to 0xD8. That value has BUSY (bit 7), ACK (bit 6), ONLINE (bit 4) and ERROR (bit 3) set.
- R4: A control write with INIT=1, SELECT (bit 3)=1 and STROBE (bit 0)=1 clears BUSY. If the stored control had STROBE=0, the data byte appears on `out_byte` with `out_valid` high for exactly one cycle, in the cycle after the write.
- R5: A control write with INIT=1, SELECT=1 and STROBE=0 sets the pending interrupt only if the stored control had interrupt-enable (bit 4) set.
- R6: The decisions in R4 and R5 use the control value held before the write. The written value is stored only after those decisions are made.
- R7: A status read returns the status held before the read and clears the pending interrupt.
- R8: On a status read where BUSY=0 and stored STROBE=0, the handshake steps forward. If ACK was set, ACK is cleared. If ACK was clear, ACK and BUSY are both set. In all other cases the status read leaves status unchanged.
- R9: `irq` equals pending AND stored interrupt-enable, and follows each register access in the next cycle.
- R10: Reads of data and control return the stored bytes one cycle after the read strobe. A data write stores the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (low three bits decoded) |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `bus_rd` |
| out_valid | output | 1 | One-cycle pulse marking an emitted byte |
| out_byte | output | 8 | Emitted printer byte |
| irq | output | 1 | Level interrupt request |

## Verification
Corrupt handshake or control state does not show on a port straight away. It shows up on the next status read as a wrong `rd_data` one cycle later, or later still as a missing or extra `out_valid` pulse, or as `irq` going the wrong way. The reference model is therefore compared against every output on every clock, and the stimulus reads status often, so that a divergence is caught within a few accesses. Back-to-back control writes cover the old-versus-new control ordering. Sequences of status reads walk the ACK/BUSY handshake through all of its steps, including the reads on which it must not move.

// File: rtl/prn_pkg.sv
// Shared constants for the emulated printer port: register offsets,
// bit positions inside control and status, and fixed status values.
package prn_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTL  = 3'd2;

    localparam int C_STROBE = 0;
    localparam int C_INIT   = 2;
    localparam int C_SELECT = 3;
    localparam int C_IEN    = 4;

    localparam int S_ERROR  = 3;
    localparam int S_ONLINE = 4;
    localparam int S_ACK    = 6;
    localparam int S_BUSY   = 7;

    localparam logic [BYTE_W-1:0] STAT_RST  = 8'h80;
    localparam logic [BYTE_W-1:0] STAT_INIT = 8'hD8;
endpackage

// File: rtl/prn_decode.sv
// Address decode for the printer port register bus.
// What it does: turns one-cycle read and write strobes into per-register
// strobes, using only the low three address bits.
// Assumes: a read and a write never arrive in the same cycle; ADDR_W >= 3.
module prn_decode #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_data,
    output logic              wr_ctl,
    output logic              rd_data,
    output logic              rd_stat,
    output logic              rd_ctl
);
    import prn_pkg::*;

    logic [2:0] off;

    // Keep only the low three address bits (address taken modulo 8).
    always_comb off = addr[2:0];

    // Produce the per-register strobes. Offsets 3..7 select nothing.
    always_comb begin
        wr_data = wr && (off == OFF_DATA);
        wr_ctl  = wr && (off == OFF_CTL);
        rd_data = rd && (off == OFF_DATA);
        rd_stat = rd && (off == OFF_STAT);
        rd_ctl  = rd && (off == OFF_CTL);
    end
endmodule

// File: rtl/prn_engine.sv
// Handshake engine for the emulated printer port.
// What it does: holds the data, control and status registers and the
// pending-interrupt flag. It applies the strobe/init/select rules on control
// writes against the old control value, emits the data byte on a strobe rising
// edge, and steps the ACK/BUSY handshake on each status read.
// Assumes: at most one of the strobe inputs is high in any cycle.
module prn_engine
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctl,
    input  logic              rd_stat,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              pend_q,
    output logic              emit_v,
    output logic [BYTE_W-1:0] emit_b
);
    logic [BYTE_W-1:0] stat_n;
    logic              pend_n;
    logic              emit_n;

    // Work out the next status, pending flag and emit request from the old control value.
    always_comb begin
        stat_n = stat_q;
        pend_n = pend_q;
        emit_n = 1'b0;
        if (wr_ctl) begin
            if (!wdata[C_INIT]) begin
                stat_n = STAT_INIT;
            end else if (wdata[C_SELECT]) begin
                if (wdata[C_STROBE]) begin
                    stat_n[S_BUSY] = 1'b0;
                    emit_n = !ctl_q[C_STROBE];
                end else if (ctl_q[C_IEN]) begin
                    pend_n = 1'b1;
                end
            end
        end else if (rd_stat) begin
            pend_n = 1'b0;
            if (!stat_q[S_BUSY] && !ctl_q[C_STROBE]) begin
                if (stat_q[S_ACK]) begin
                    stat_n[S_ACK] = 1'b0;
                end else begin
                    stat_n[S_ACK]  = 1'b1;
                    stat_n[S_BUSY] = 1'b1;
                end
            end
        end
    end

    // Register state. Control is stored after the checks above have used its old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= STAT_RST;
            ctl_q  <= '0;
            pend_q <= 1'b0;
            emit_v <= 1'b0;
            emit_b <= '0;
        end else begin
            stat_q <= stat_n;
            pend_q <= pend_n;
            emit_v <= emit_n;
            if (emit_n) emit_b <= data_q;
            if (wr_data) data_q <= wdata;
            if (wr_ctl)  ctl_q  <= wdata;
        end
    end

    // R3
    init_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata[C_INIT]) |=> (stat_q == STAT_INIT));

    // R4
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[C_INIT] && wdata[C_SELECT] && wdata[C_STROBE]) |=> !stat_q[S_BUSY]);

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_v |=> !emit_v);

    // R5
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(ctl_q[C_IEN]));

    // R7
    read_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> !pend_q);
endmodule

// File: rtl/prn_port_regs.sv
// Top of the emulated printer port register block.
// What it does: decodes the register bus, runs the handshake engine,
// registers read data one cycle after a read, and drives the level interrupt.
// Assumes: single-cycle bus with no simultaneous read and write.
module prn_port_regs #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              irq
);
    import prn_pkg::*;

    logic              s_wr_data, s_wr_ctl, s_rd_data, s_rd_stat, s_rd_ctl;
    logic [BYTE_W-1:0] data_q, stat_q, ctl_q;
    logic              pend_q;

    prn_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wr_data (s_wr_data),
        .wr_ctl  (s_wr_ctl),
        .rd_data (s_rd_data),
        .rd_stat (s_rd_stat),
        .rd_ctl  (s_rd_ctl)
    );

    prn_engine eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (s_wr_data),
        .wr_ctl  (s_wr_ctl),
        .rd_stat (s_rd_stat),
        .wdata   (bus_wdata),
        .data_q  (data_q),
        .stat_q  (stat_q),
        .ctl_q   (ctl_q),
        .pend_q  (pend_q),
        .emit_v  (out_valid),
        .emit_b  (out_byte)
    );

    // Register the read data; unmapped offsets return zero; hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (bus_rd) begin
            if (s_rd_data)      rd_data <= data_q;
            else if (s_rd_stat) rd_data <= stat_q;
            else if (s_rd_ctl)  rd_data <= ctl_q;
            else                rd_data <= '0;
        end
    end

    // Interrupt level follows the pending flag gated by the stored enable.
    always_comb irq = pend_q && ctl_q[C_IEN];

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[2:0] > 3'd2)) |=> (rd_data == '0));

    // R10
    data_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] == OFF_DATA) |=> (rd_data == $past(data_q)));
endmodule

// File: tb/prn_port_regs_tb_top.sv
// Bench: behavioural reference model compared against every output on every clock.
module prn_port_regs_tb_top;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    rd_data;
    logic          out_valid;
    logic [7:0]    out_byte;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R2";

    // Reference state
    int m_data, m_stat, m_ctl, m_rdata, m_ob;
    bit m_pend, m_ov;

    always #4 clk = ~clk;

    prn_port_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .out_valid(out_valid), .out_byte(out_byte), .irq(irq)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_stat = 'h80; m_ctl = 0; m_rdata = 0;
            m_ob = 0; m_pend = 0; m_ov = 0;
        end else begin
            m_ov = 0;
            if (bus_wr) begin
                case (int'(bus_addr) % 8)
                    0: m_data = int'(bus_wdata);
                    2: begin
                        if (bus_wdata[2] == 0) m_stat = 'hD8;
                        else if (bus_wdata[3]) begin
                            if (bus_wdata[0]) begin
                                m_stat = m_stat & 'h7F;
                                if ((m_ctl & 1) == 0) begin m_ov = 1; m_ob = m_data; end
                            end else if ((m_ctl & 'h10) != 0) m_pend = 1;
                        end
                        m_ctl = int'(bus_wdata);
                    end
                    default: ;
                endcase
            end else if (bus_rd) begin
                case (int'(bus_addr) % 8)
                    0: m_rdata = m_data;
                    1: begin
                        m_rdata = m_stat;
                        m_pend = 0;
                        if ((m_stat & 'h80) == 0 && (m_ctl & 1) == 0) begin
                            if ((m_stat & 'h40) != 0) m_stat = m_stat & 'hBF;
                            else m_stat = m_stat | 'hC0;
                        end
                    end
                    2: m_rdata = m_ctl;
                    default: m_rdata = 0;
                endcase
            end
        end
    end

    task automatic compare();
        bit m_irq;
        m_irq = m_pend && ((m_ctl & 'h10) != 0);
        n_cmp++;
        if (rd_data !== 8'(m_rdata) || out_valid !== m_ov || irq !== m_irq ||
            (m_ov && out_byte !== 8'(m_ob))) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h/%02h out_valid=%0b/%0b out_byte=%02h/%02h irq=%0b/%0b (actual/expected)",
                     cur_req, rd_data, 8'(m_rdata), out_valid, m_ov, out_byte, 8'(m_ob), irq, m_irq);
        end
    endtask

    // One bus cycle: compare at the falling edge, then drive the next request.
    task automatic cyc(input bit w, input bit r, input int a, input int d);
        @(negedge clk);
        if (rst_n) compare();
        bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = 8'(d);
    endtask

    task automatic wr(input int a, input int d); cyc(1, 0, a, d); cyc(0, 0, 0, 0); endtask
    task automatic rd(input int a);              cyc(0, 1, a, 0); cyc(0, 0, 0, 0); endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R2";
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        rd(1); rd(0); rd(2);
        cur_req = "R10";
        wr(0, 'hA5); rd(0);
        cur_req = "R1";
        rd(8); wr(5, 'h77); rd(5); rd(0); rd(3); rd(7); wr(9, 'h11); rd(2);
        cur_req = "R3";
        wr(2, 'h00); rd(1);
        cur_req = "R4";
        wr(2, 'h0C); wr(0, 'h3C); wr(2, 'h0D); rd(1);
        cur_req = "R6";
        wr(0, 'h44); wr(2, 'h0D); rd(1);
        cur_req = "R8";
        rd(1); wr(2, 'h0C); rd(1); rd(1); rd(1); rd(1);
        cur_req = "R5";
        wr(2, 'h1C); wr(2, 'h1C);
        cur_req = "R9";
        wr(2, 'h0C); wr(0, 'h55); wr(2, 'h1C); wr(2, 'h18);
        cur_req = "R7";
        rd(1); rd(1);
        cur_req = "R4";
        wr(2, 'h1D); wr(2, 'h1C); wr(2, 'h1D);
        cur_req = "R6";
        wr(2, 'h14); wr(2, 'h1C); wr(2, 'h1C); cyc(0, 1, 1, 0); cyc(1, 0, 2, 'h0D);
        cyc(1, 0, 2, 'h0C); cyc(1, 0, 2, 'h0D); cyc(0, 0, 0, 0);
        cur_req = "R8 mixed";
        for (int i = 0; i < 2000; i++) begin
            int a, d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = (lf[3:2] == 2'b11) ? int'(lf[6:4]) : int'(lf[3:2]);
            d = int'(lf[15:8]) | 'h04;
            if (lf[9:8] == 2'b00) d = d & 'hFB;
            case (lf[1:0])
                2'b00: cyc(1, 0, a, d);
                2'b11: cyc(0, 0, 0, 0);
                default: cyc(0, 1, (lf[7] ? 1 : a), 0);
            endcase
        end
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule